// File: doc/BRIEF.md
# LCD Driver Control State and Pixel Gate

This block keeps the control registers of a small matrix LCD row/column driver. The registers cover power-down, display mode, addressing direction, instruction page select, the X/Y address counters and their upper limits, mirroring, row-order swap, data order, the partial-row mask and the analog settings. A decoded command port writes one register group per accepted command. An active-low reset pin and a software reset command each load the same defaults. A reset also opens a fixed window in which the block reports itself busy and accepts no command.

A status byte gives busy, display-on and reset-in-progress flags, a manufacturer code and a device code. Each pixel bit read from display RAM passes through the selected display mode and the power-down override to give the segment drive level. The display-enable strobe gates that drive.

Top module: `lcd_ctrl_state`

## Requirements
- R1: While `rst_n` is low and in the cycles after it, the registers hold these values: pd=1, vert=0, ext_set=0, disp_mode=00, x_addr=0, y_addr=0, x_max=101, y_max=8, row_mask=8'hFF, pwr_ctl=1, row_norm=1, and 0 in mir_x, mir_y, row_swap, data_order, temp_coef, mult_sel, bias_sel, start_line and line_addr. Pulling `rst_n` low applies these values at once, with no clock edge needed.
- R2: An accepted command with `cmd_addr`=15 loads the same values as R1 at the next clock edge.
- R3: The status byte is laid out as {BUSY, DON, RES, MF[2:0], 2'b00}, bit 7 first. BUSY and RES are both 1 during a reset window. After a software reset command is accepted, that window lasts exactly 8 clock cycles.
- R4: A command presented while BUSY=1 changes no register and does not restart the window.
- R5: An accepted command writes the addressed register group. The groups are: 0 takes {pd,vert,ext_set} from data[2:0]; 1 takes disp_mode from data[1:0] (bit 1 is D, bit 0 is E); 2 takes x_addr; 3 takes y_addr; 4 takes x_max; 5 takes y_max; 6 takes row_mask; 7 takes pwr_ctl, row_norm, mir_x, mir_y, row_swap and data_order from bits 0 to 5; 8 takes start_line; 9 takes line_addr; 10 takes temp_coef from [1:0], mult_sel from [3:2] and bias_sel from [6:4].
- R6: DON reads 1 exactly when pd=0 and disp_mode is not 00. MF equals the parameter `MFR_ID` (default 3'b101). The two low status bits are 0.
- R7: With pd=0 and `pix_en`=1, `pix_drive` depends on disp_mode. It is 0 for 00 (blank), `pix_ram` for 10 (normal), 1 for 01 (all on), and the complement of `pix_ram` for 11 (inverse).
- R8: While pd=1, `pix_drive` is 0 whatever the mode and RAM bit are.
- R9: While `pix_en`=0, `pix_drive` is 0.
- R10: Commands to addresses 11 to 14 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset pin |
| cmd_valid | input | 1 | Command strobe |
| cmd_addr | input | 4 | Register group select |
| cmd_data | input | 8 | Command payload |
| pix_ram | input | 1 | Pixel bit from display RAM |
| pix_en | input | 1 | Display-enable strobe |
| pix_drive | output | 1 | Segment drive level |
| status | output | 8 | Status byte |
| pd | output | 1 | Power-down |
| vert | output | 1 | Vertical addressing |
| ext_set | output | 1 | Extended instruction page |
| disp_mode | output | 2 | Display mode {D,E} |
| x_addr | output | 7 | X address counter |
| y_addr | output | 4 | Y address counter |
| x_max | output | 7 | X address limit |
| y_max | output | 4 | Y address limit |
| row_mask | output | 8 | Partial-row enable mask |
| pwr_ctl | output | 1 | Power control enable |
| row_norm | output | 1 | Normal row driving |
| mir_x | output | 1 | Horizontal mirror |
| mir_y | output | 1 | Vertical mirror |
| row_swap | output | 1 | Row order swap |
| data_order | output | 1 | Data bit order |
| temp_coef | output | 2 | Temperature coefficient select |
| mult_sel | output | 2 | Voltage multiplier select |
| bias_sel | output | 3 | Bias select |
| start_line | output | 7 | Display start line |
| line_addr | output | 7 | RAM line address |

## Verification
Two functions can fall in the same cycle: the end of a reset window and a command write. The bench holds a write on the port through every busy cycle, including the last one. After that cycle the register read-back must still show the defaults. A write presented in the first cycle with BUSY=0 must then take effect. The same check runs after a second software reset issued in the middle of the window, and after a reset pin pulse applied over non-default state. The status flags are sampled in each of these cycles.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam int XW = 7;
  localparam int YW = 4;
  localparam int LW = 7;
  localparam int MW = 8;

  typedef enum logic [1:0] {
    DM_BLANK   = 2'b00,
    DM_ALLON   = 2'b01,
    DM_NORMAL  = 2'b10,
    DM_INVERSE = 2'b11
  } disp_mode_e;

  typedef enum logic [3:0] {
    CA_FUNC   = 4'd0,
    CA_DISP   = 4'd1,
    CA_XADDR  = 4'd2,
    CA_YADDR  = 4'd3,
    CA_XMAX   = 4'd4,
    CA_YMAX   = 4'd5,
    CA_MASK   = 4'd6,
    CA_MISC   = 4'd7,
    CA_START  = 4'd8,
    CA_LINE   = 4'd9,
    CA_ANALOG = 4'd10,
    CA_SWRST  = 4'd15
  } cmd_addr_e;

  typedef struct packed {
    logic          pd;
    logic          vert;
    logic          ext_set;
    logic [1:0]    mode;
    logic [XW-1:0] x_addr;
    logic [YW-1:0] y_addr;
    logic [XW-1:0] x_max;
    logic [YW-1:0] y_max;
    logic [MW-1:0] row_mask;
    logic          pwr_ctl;
    logic          row_norm;
    logic          mir_x;
    logic          mir_y;
    logic          row_swap;
    logic          data_order;
    logic [1:0]    temp_coef;
    logic [1:0]    mult_sel;
    logic [2:0]    bias_sel;
    logic [LW-1:0] start_line;
    logic [LW-1:0] line_addr;
  } ctl_regs_t;

  function automatic ctl_regs_t ctl_defaults(input logic [XW-1:0] xm,
                                             input logic [YW-1:0] ym);
    ctl_regs_t r;
    r          = '0;
    r.pd       = 1'b1;
    r.mode     = DM_BLANK;
    r.x_max    = xm;
    r.y_max    = ym;
    r.row_mask = '1;
    r.pwr_ctl  = 1'b1;
    r.row_norm = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/lcdc_rst_seq.sv
module lcdc_rst_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  output logic rst_i_n,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q[g] <= 1'b0;
        end else begin
          if (g == 0) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign rst_i_n = sync_q[SYNC_STAGES-1];

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (soft_rst)         cnt_nxt = CNT_LOAD;
    else if (cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) cnt_q <= CNT_LOAD;
    else          cnt_q <= cnt_nxt;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
  import lcdc_pkg::*;
#(
  parameter logic [XW-1:0] XMAX_RST = 7'd101,
  parameter logic [YW-1:0] YMAX_RST = 4'd8
) (
  input  logic       clk,
  input  logic       rst_i_n,
  input  logic       soft_rst,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output ctl_regs_t  regs
);
  localparam ctl_regs_t DEFAULTS = ctl_defaults(XMAX_RST, YMAX_RST);

  ctl_regs_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (soft_rst) begin
      nxt = DEFAULTS;
    end else if (wr_en) begin
      case (cmd_addr_e'(wr_addr))
        CA_FUNC: begin
          nxt.pd      = wr_data[2];
          nxt.vert    = wr_data[1];
          nxt.ext_set = wr_data[0];
        end
        CA_DISP:  nxt.mode     = wr_data[1:0];
        CA_XADDR: nxt.x_addr   = wr_data[XW-1:0];
        CA_YADDR: nxt.y_addr   = wr_data[YW-1:0];
        CA_XMAX:  nxt.x_max    = wr_data[XW-1:0];
        CA_YMAX:  nxt.y_max    = wr_data[YW-1:0];
        CA_MASK:  nxt.row_mask = wr_data[MW-1:0];
        CA_MISC: begin
          nxt.pwr_ctl    = wr_data[0];
          nxt.row_norm   = wr_data[1];
          nxt.mir_x      = wr_data[2];
          nxt.mir_y      = wr_data[3];
          nxt.row_swap   = wr_data[4];
          nxt.data_order = wr_data[5];
        end
        CA_START: nxt.start_line = wr_data[LW-1:0];
        CA_LINE:  nxt.line_addr  = wr_data[LW-1:0];
        CA_ANALOG: begin
          nxt.temp_coef = wr_data[1:0];
          nxt.mult_sel  = wr_data[3:2];
          nxt.bias_sel  = wr_data[6:4];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) cur_q <= DEFAULTS;
    else          cur_q <= nxt;
  end

  assign regs = cur_q;
endmodule

// File: rtl/lcdc_pix.sv
module lcdc_pix
  import lcdc_pkg::*;
(
  input  logic       pd,
  input  logic [1:0] mode,
  input  logic       ram_bit,
  input  logic       en,
  output logic       drive
);
  logic lvl;

  always_comb begin
    case (disp_mode_e'(mode))
      DM_NORMAL:  lvl = ram_bit;
      DM_ALLON:   lvl = 1'b1;
      DM_INVERSE: lvl = ~ram_bit;
      default:    lvl = 1'b0;
    endcase
  end

  assign drive = en & ~pd & lvl;
endmodule

// File: rtl/lcd_ctrl_state.sv
module lcd_ctrl_state
  import lcdc_pkg::*;
#(
  parameter int             SYNC_STAGES = 2,
  parameter int             RST_CYCLES  = 8,
  parameter logic [2:0]     MFR_ID      = 3'b101,
  parameter logic [XW-1:0]  XMAX_RST    = 7'd101,
  parameter logic [YW-1:0]  YMAX_RST    = 4'd8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_addr,
  input  logic [7:0]   cmd_data,
  input  logic         pix_ram,
  input  logic         pix_en,
  output logic         pix_drive,
  output logic [7:0]   status,
  output logic         pd,
  output logic         vert,
  output logic         ext_set,
  output logic [1:0]   disp_mode,
  output logic [6:0]   x_addr,
  output logic [3:0]   y_addr,
  output logic [6:0]   x_max,
  output logic [3:0]   y_max,
  output logic [7:0]   row_mask,
  output logic         pwr_ctl,
  output logic         row_norm,
  output logic         mir_x,
  output logic         mir_y,
  output logic         row_swap,
  output logic         data_order,
  output logic [1:0]   temp_coef,
  output logic [1:0]   mult_sel,
  output logic [2:0]   bias_sel,
  output logic [6:0]   start_line,
  output logic [6:0]   line_addr
);
  logic      rst_i_n, busy, accept, soft_rst, wr_en, don;
  ctl_regs_t regs;

  assign accept   = cmd_valid & ~busy;
  assign soft_rst = accept & (cmd_addr == CA_SWRST);
  assign wr_en    = accept & ~soft_rst;

  lcdc_rst_seq #(
    .SYNC_STAGES (SYNC_STAGES),
    .RST_CYCLES  (RST_CYCLES)
  ) i_rst_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .rst_i_n  (rst_i_n),
    .busy     (busy)
  );

  lcdc_regfile #(
    .XMAX_RST (XMAX_RST),
    .YMAX_RST (YMAX_RST)
  ) i_regfile (
    .clk      (clk),
    .rst_i_n  (rst_i_n),
    .soft_rst (soft_rst),
    .wr_en    (wr_en),
    .wr_addr  (cmd_addr),
    .wr_data  (cmd_data),
    .regs     (regs)
  );

  lcdc_pix i_pix (
    .pd      (regs.pd),
    .mode    (regs.mode),
    .ram_bit (pix_ram),
    .en      (pix_en),
    .drive   (pix_drive)
  );

  assign don    = ~regs.pd & (regs.mode != DM_BLANK);
  assign status = {busy, don, busy, MFR_ID, 2'b00};

  assign pd         = regs.pd;
  assign vert       = regs.vert;
  assign ext_set    = regs.ext_set;
  assign disp_mode  = regs.mode;
  assign x_addr     = regs.x_addr;
  assign y_addr     = regs.y_addr;
  assign x_max      = regs.x_max;
  assign y_max      = regs.y_max;
  assign row_mask   = regs.row_mask;
  assign pwr_ctl    = regs.pwr_ctl;
  assign row_norm   = regs.row_norm;
  assign mir_x      = regs.mir_x;
  assign mir_y      = regs.mir_y;
  assign row_swap   = regs.row_swap;
  assign data_order = regs.data_order;
  assign temp_coef  = regs.temp_coef;
  assign mult_sel   = regs.mult_sel;
  assign bias_sel   = regs.bias_sel;
  assign start_line = regs.start_line;
  assign line_addr  = regs.line_addr;
endmodule

// File: rtl/lcd_ctrl_state_chk.sv
module lcd_ctrl_state_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [3:0]  cmd_addr,
  input logic [7:0]  cmd_data,
  input logic [7:0]  status,
  input logic        pd,
  input logic [1:0]  disp_mode,
  input logic [7:0]  row_mask,
  input logic [6:0]  x_max,
  input logic        pix_drive,
  input logic [61:0] regs_flat
);
  assert_busy_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && status[7]) |=> $stable(regs_flat));

  assert_swrst_defaults_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !status[7] && cmd_addr == 4'd15) |=>
      (pd && disp_mode == 2'b00 && row_mask == 8'hFF && x_max == 7'd101 && status[7]));

  assert_res_busy_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] == status[5]) && (status[1:0] == 2'b00));

  assert_don_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] == (!pd && disp_mode != 2'b00));

  assert_pd_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> !pix_drive);

  assert_mode_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !status[7] && cmd_addr == 4'd1) |=> disp_mode == $past(cmd_data[1:0]));
endmodule

bind lcd_ctrl_state lcd_ctrl_state_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data),
  .status    (status),
  .pd        (pd),
  .disp_mode (disp_mode),
  .row_mask  (row_mask),
  .x_max     (x_max),
  .pix_drive (pix_drive),
  .regs_flat ({pd, vert, ext_set, disp_mode, x_addr, y_addr, x_max, y_max, row_mask,
               pwr_ctl, row_norm, mir_x, mir_y, row_swap, data_order,
               temp_coef, mult_sel, bias_sel, start_line, line_addr})
);

// File: tb/test_lcd_ctrl_state.sv
`timescale 1ns/1ps
module test_lcd_ctrl_state;
  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [3:0] cmd_addr;
  logic [7:0] cmd_data;
  logic pix_ram, pix_en, pix_drive;
  logic [7:0] status;
  logic pd, vert, ext_set, pwr_ctl, row_norm, mir_x, mir_y, row_swap, data_order;
  logic [1:0] disp_mode, temp_coef, mult_sel;
  logic [2:0] bias_sel;
  logic [6:0] x_addr, x_max, start_line, line_addr;
  logic [3:0] y_addr, y_max;
  logic [7:0] row_mask;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  lcd_ctrl_state i_lcd_ctrl_state (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .pix_ram(pix_ram), .pix_en(pix_en), .pix_drive(pix_drive),
    .status(status), .pd(pd), .vert(vert), .ext_set(ext_set), .disp_mode(disp_mode),
    .x_addr(x_addr), .y_addr(y_addr), .x_max(x_max), .y_max(y_max), .row_mask(row_mask),
    .pwr_ctl(pwr_ctl), .row_norm(row_norm), .mir_x(mir_x), .mir_y(mir_y),
    .row_swap(row_swap), .data_order(data_order), .temp_coef(temp_coef),
    .mult_sel(mult_sel), .bias_sel(bias_sel), .start_line(start_line),
    .line_addr(line_addr)
  );

  // bench model of the register state
  logic [61:0] m;
  localparam logic [61:0] DEF = {1'b1, 1'b0, 1'b0, 2'b00, 7'd0, 4'd0, 7'd101, 4'd8,
                                 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                 2'd0, 2'd0, 3'd0, 7'd0, 7'd0};

  function automatic logic [61:0] got_regs();
    return {pd, vert, ext_set, disp_mode, x_addr, y_addr, x_max, y_max, row_mask,
            pwr_ctl, row_norm, mir_x, mir_y, row_swap, data_order,
            temp_coef, mult_sel, bias_sel, start_line, line_addr};
  endfunction

  function automatic logic [61:0] model_write(input logic [61:0] s,
                                              input logic [3:0] a, input logic [7:0] d);
    logic [61:0] r;
    r = s;
    case (a)
      4'd0:  r[61:59] = d[2:0];
      4'd1:  r[58:57] = d[1:0];
      4'd2:  r[56:50] = d[6:0];
      4'd3:  r[49:46] = d[3:0];
      4'd4:  r[45:39] = d[6:0];
      4'd5:  r[38:35] = d[3:0];
      4'd6:  r[34:27] = d;
      4'd7:  r[26:21] = {d[0], d[1], d[2], d[3], d[4], d[5]};
      4'd8:  r[13:7]  = d[6:0];
      4'd9:  r[6:0]   = d[6:0];
      4'd10: r[20:14] = {d[1:0], d[3:2], d[6:4]};
      4'd15: r = DEF;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic exp_pix(input logic p, input logic [1:0] md,
                                   input logic ram, input logic en);
    logic l;
    case (md)
      2'b10:   l = ram;
      2'b01:   l = 1'b1;
      2'b11:   l = ~ram;
      default: l = 1'b0;
    endcase
    return en && !p && l;
  endfunction

  function automatic logic [7:0] exp_status(input logic bsy, input logic [61:0] s);
    logic on;
    on = !s[61] && (s[58:57] != 2'b00);
    return {bsy, on, bsy, 3'b101, 2'b00};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    check(got_regs() === m, req, {2'b0, got_regs()}, {2'b0, m});
  endtask

  // present a command for one edge, then sample at the following negedge
  task automatic put_cmd(input logic [3:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    put_cmd(a, d);
    m = model_write(m, a, d);
  endtask

  // counts busy cycles; holds a write on the port through every busy cycle
  task automatic ride_out_busy(output int n);
    n = 0;
    while (status[7] === 1'b1 && n < 50) begin
      n++;
      put_cmd(4'd2, 8'h55);
    end
  endtask

  initial begin
    int nb;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_data = '0;
    pix_ram = 1'b0; pix_en = 1'b0;
    void'($urandom(32'd1234));
    m = DEF;
    repeat (3) @(negedge clk);
    chk_regs("R1 pin reset defaults");
    check(status === 8'b1011_0100, "R3 status in reset", {56'b0, status}, 64'hB4);
    rst_n = 1'b1;
    ride_out_busy(nb);
    chk_regs("R4 writes ignored during power-up window");
    check(status === exp_status(1'b0, m), "R6 status after window", {56'b0, status},
          {56'b0, exp_status(1'b0, m)});

    // first write after window is accepted
    wr(4'd2, 8'h2A);
    chk_regs("R5 write after busy clears");

    // soft reset: exact window length, writes ignored during it
    wr(4'd7, 8'h3C);
    wr(4'd1, 8'h03);
    wr(4'd0, 8'h00);
    put_cmd(4'd15, 8'h00);
    m = DEF;
    check(status === 8'b1011_0100, "R3 busy after soft reset", {56'b0, status}, 64'hB4);
    chk_regs("R2 soft reset defaults");
    ride_out_busy(nb);
    check(nb == 8, "R3 window length", 64'(nb), 64'd8);
    chk_regs("R4 write on last busy cycle ignored");
    wr(4'd3, 8'h07);
    chk_regs("R5 write on first free cycle");

    // soft reset command issued mid-window is ignored (no restart)
    put_cmd(4'd15, 8'h00);
    m = DEF;
    repeat (3) put_cmd(4'd15, 8'h00);
    ride_out_busy(nb);
    check(nb == 5, "R4 window not restarted", 64'(nb), 64'd5);

    // unused addresses
    for (int a = 11; a <= 14; a++) begin
      put_cmd(4'(a), 8'hFF);
      chk_regs("R10 unused address ignored");
    end

    // pixel modes directed
    wr(4'd0, 8'h00);
    for (int md = 0; md < 4; md++) begin
      wr(4'd1, 8'(md));
      for (int k = 0; k < 4; k++) begin
        pix_ram = k[0]; pix_en = k[1];
        #1;
        check(pix_drive === exp_pix(1'b0, 2'(md), k[0], k[1]),
              k[1] ? "R7 mode gating" : "R9 enable low", {63'b0, pix_drive},
              {63'b0, exp_pix(1'b0, 2'(md), k[0], k[1])});
      end
      check(status === exp_status(1'b0, m), "R6 DON per mode", {56'b0, status},
            {56'b0, exp_status(1'b0, m)});
    end
    wr(4'd0, 8'h04);
    pix_en = 1'b1; pix_ram = 1'b0;
    #1;
    check(pix_drive === 1'b0, "R8 power-down inverse", {63'b0, pix_drive}, 64'd0);

    // constrained random commands and pixels
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      a = 4'($urandom_range(0, 14));
      d = 8'($urandom);
      wr(a, d);
      chk_regs("R5 random write");
      pix_ram = 1'($urandom); pix_en = 1'($urandom);
      #1;
      check(pix_drive === exp_pix(m[61], m[58:57], pix_ram, pix_en),
            m[61] ? "R8 random pixel" : "R7 random pixel", {63'b0, pix_drive},
            {63'b0, exp_pix(m[61], m[58:57], pix_ram, pix_en)});
      check(status === exp_status(1'b0, m), "R6 random status", {56'b0, status},
            {56'b0, exp_status(1'b0, m)});
    end

    // pin reset over non-default state takes effect without a clock edge
    wr(4'd6, 8'h0F);
    wr(4'd0, 8'h03);
    #1 rst_n = 1'b0;
    #0.5;
    m = DEF;
    chk_regs("R1 asynchronous pin reset");
    @(negedge clk);
    rst_n = 1'b1;
    ride_out_busy(nb);
    chk_regs("R1 defaults after pin release");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule